// File: doc/BRIEF.md
# Infrared Transceiver Control Logic

This block models, in synthesizable form, the digital control of a half-duplex infrared transceiver. It takes the transmit data pin, the shutdown/mode pin and a digitized "light seen" flag. It drives the emitter enable, the active-low receive data output, an output enable for the receive pin's tri-state buffer, and the current receiver bandwidth mode.

Microsecond-scale timing comes from a clock of known frequency. The parameter `CLK_PER_US` gives the clock cycles per microsecond, and the emitter guard time and the shutdown qualification time are derived from it. All three inputs pass through a two-flop synchronizer before any edge detection or timing.

A long high level on the shutdown pin powers the block down. A short pulse on the same pin only reprograms the receiver bandwidth: the bandwidth is taken from the transmit pin at the pulse's falling edge.

Top module: `irxcvr_ctrl`

## Requirements
- R1: After reset `ledOn` is 0, `rxdOut` is 1, `rxdOe` is 1 and `bwHigh` is 0 (low-bandwidth mode).
- R2: With the shutdown pin low, `ledOn` follows the transmit pin. It goes to 1 within 3 clocks of `txdIn` rising and to 0 within 3 clocks of `txdIn` falling.
- R3: When `txdIn` stays high continuously, `ledOn` is forced to 0 after `LED_TIMEOUT_US` microseconds (`LED_TIMEOUT_US*CLK_PER_US` clocks of synchronized high). It stays 0 while `txdIn` remains high.
- R4: The guard timer restarts whenever `txdIn` goes low. The next high pulse on `txdIn` again keeps the emitter lit for the full guard time.
- R5: A high level on `sdIn` shorter than `SHDN_US` microseconds does not shut the block down: `rxdOe` stays 1. While `sdIn` is high, `ledOn` is 0 and `rxdOut` is 1.
- R6: Once `sdIn` has been high for more than `SHDN_US` microseconds, `rxdOe` is 0 and `ledOn` is 0, whatever `txdIn` and `lightIn` do.
- R7: On every synchronized falling edge of `sdIn`, `bwHigh` loads the level of `txdIn` (1 = high bandwidth, 0 = low bandwidth). `bwHigh` holds at all other times.
- R8: Leaving shutdown by lowering `sdIn` also loads `bwHigh` from `txdIn`, and `rxdOe` returns to 1.
- R9: With `sdIn` low, `rxdOut` is 0 while `lightIn` is 1 or the emitter is lit (the receiver echoes the transmitter), and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock, `CLK_PER_US` cycles per microsecond |
| rstN | input | 1 | Asynchronous active-low reset |
| txdIn | input | 1 | Transmit data pin, active high |
| sdIn | input | 1 | Shutdown and mode-programming pin, active high |
| lightIn | input | 1 | Digitized in-band light detect flag |
| ledOn | output | 1 | Emitter drive enable |
| rxdOut | output | 1 | Receive data, active low |
| rxdOe | output | 1 | Output enable for the receive pin tri-state |
| bwHigh | output | 1 | Receiver bandwidth mode, 1 = high bandwidth |

## Verification
A guard counter that fails to clear or saturate shows at the emitter pin. Either the second pulse is cut short or the emitter stays lit past the guard time, visible within a few clocks of the threshold. A shutdown counter with a wrong limit turns `rxdOe` off during a short mode pulse, or fails to turn it off a few clocks past the qualification time. A wrongly captured bandwidth bit appears on `bwHigh` three clocks after the shutdown pin falls and persists until the next falling edge.

// File: rtl/irx_pkg.sv
package irx_pkg;
  // Strobes from the control timers to the output datapath
  typedef struct packed {
    logic ledGate;   // emitter allowed and requested
    logic sdHigh;    // synchronized shutdown pin is high
    logic shutdown;  // qualified shutdown state
    logic bwLoad;    // load bandwidth register this cycle
    logic bwVal;     // value to load
  } ctrlStrobe_t;
endpackage

// File: rtl/irx_sync.sv
module irx_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta       <= 1'b0;
        syncOut[i] <= 1'b0;
      end else begin
        meta       <= asyncIn[i];
        syncOut[i] <= meta;
      end
    end
  end
endmodule

// File: rtl/irx_ctrl.sv
module irx_ctrl
  import irx_pkg::*;
#(
  parameter int CLK_PER_US     = 100,
  parameter int LED_TIMEOUT_US = 50,
  parameter int SHDN_US        = 400
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        txdS,
  input  logic        sdS,
  output ctrlStrobe_t strobe
);
  localparam int LED_CYC = LED_TIMEOUT_US * CLK_PER_US;
  localparam int SHDN_CYC = SHDN_US * CLK_PER_US;
  localparam int TX_W = $clog2(LED_CYC + 1);
  localparam int SD_W = $clog2(SHDN_CYC + 1);
  localparam logic [TX_W-1:0] TX_MAX = TX_W'(LED_CYC);
  localparam logic [SD_W-1:0] SD_MAX = SD_W'(SHDN_CYC);

  logic [TX_W-1:0] txCnt;
  logic [SD_W-1:0] sdCnt;
  logic            sdPrev;

  // Emitter guard timer: counts synchronized TXD-high cycles, clears on low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txCnt <= '0;
    else if (!txdS) txCnt <= '0;
    else if (txCnt != TX_MAX) txCnt <= txCnt + 1'b1;
  end

  // Shutdown qualifier: counts synchronized SD-high cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdCnt  <= '0;
      sdPrev <= 1'b0;
    end else begin
      sdPrev <= sdS;
      if (!sdS) sdCnt <= '0;
      else if (sdCnt != SD_MAX) sdCnt <= sdCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.ledGate  = txdS && !sdS && (txCnt != TX_MAX);
    strobe.sdHigh   = sdS;
    strobe.shutdown = (sdCnt == SD_MAX);
    strobe.bwLoad   = sdPrev && !sdS;
    strobe.bwVal    = txdS;
  end

  AST_TX_CAP: assert property (@(posedge clk) disable iff (!rstN)
    txCnt <= TX_MAX); // R3
  AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !txdS |=> (txCnt == '0)); // R4
  AST_SD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !sdS |=> (sdCnt == '0)); // R5
  AST_SHDN_AFTER_SD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.shutdown) |-> $past(sdS)); // R6
endmodule

// File: rtl/irx_datapath.sv
module irx_datapath
  import irx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        lightS,
  output logic        ledOn,
  output logic        rxdOut,
  output logic        rxdOe,
  output logic        bwHigh
);
  logic bwQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bwQ <= 1'b0;
    else if (strobe.bwLoad) bwQ <= strobe.bwVal;
  end

  always_comb begin
    ledOn  = strobe.ledGate && !strobe.shutdown;
    rxdOut = strobe.sdHigh ? 1'b1 : !(lightS || ledOn);
    rxdOe  = !strobe.shutdown;
    bwHigh = bwQ;
  end

  AST_BW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.bwLoad |=> $stable(bwQ)); // R7
  AST_RXD_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    ledOn |-> !rxdOut); // R9
endmodule

// File: rtl/irxcvr_ctrl.sv
module irxcvr_ctrl
  import irx_pkg::*;
#(
  parameter int CLK_PER_US     = 100,
  parameter int LED_TIMEOUT_US = 50,
  parameter int SHDN_US        = 400
) (
  input  logic clk,
  input  logic rstN,
  input  logic txdIn,
  input  logic sdIn,
  input  logic lightIn,
  output logic ledOn,
  output logic rxdOut,
  output logic rxdOe,
  output logic bwHigh
);
  logic [2:0]  syncVec;
  ctrlStrobe_t strobe;

  irx_sync #(.WIDTH(3)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({lightIn, sdIn, txdIn}),
    .syncOut (syncVec)
  );

  irx_ctrl #(
    .CLK_PER_US     (CLK_PER_US),
    .LED_TIMEOUT_US (LED_TIMEOUT_US),
    .SHDN_US        (SHDN_US)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .txdS   (syncVec[0]),
    .sdS    (syncVec[1]),
    .strobe (strobe)
  );

  irx_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .lightS (syncVec[2]),
    .ledOn  (ledOn),
    .rxdOut (rxdOut),
    .rxdOe  (rxdOe),
    .bwHigh (bwHigh)
  );
endmodule

// File: tb/irxcvr_ctrl_bench.sv
module irxcvr_ctrl_bench;
  localparam int CPU = 4;
  localparam int LED_US = 50;
  localparam int SHDN_US = 400;
  localparam int LED_CYC = CPU * LED_US;
  localparam int SHDN_CYC = CPU * SHDN_US;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txdIn = 1'b0, sdIn = 1'b0, lightIn = 1'b0;
  logic ledOn, rxdOut, rxdOe, bwHigh;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irxcvr_ctrl #(.CLK_PER_US(CPU), .LED_TIMEOUT_US(LED_US), .SHDN_US(SHDN_US)) u_irxcvr_ctrl (
    .clk(clk), .rstN(rstN), .txdIn(txdIn), .sdIn(sdIn), .lightIn(lightIn),
    .ledOn(ledOn), .rxdOut(rxdOut), .rxdOe(rxdOe), .bwHigh(bwHigh)
  );

  // {sd, txd, light, expLed, expRxd}; every row expects rxdOe = 1
  localparam logic [4:0] VEC [6] = '{
    5'b000_01, 5'b001_00, 5'b010_10, 5'b011_10, 5'b101_01, 5'b110_01
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    txdIn = 1'b0; sdIn = 1'b0; lightIn = 1'b0;
    rstN = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(3);
  endtask

  initial begin
    waitCyc(2);
    // R1 reset state
    check("R1 led", ledOn, 1'b0);
    check("R1 rxd", rxdOut, 1'b1);
    check("R1 oe", rxdOe, 1'b1);
    check("R1 bw", bwHigh, 1'b0);
    rstN = 1'b1;
    waitCyc(3);

    // Table walk: R2, R5, R9
    for (int i = 0; i < 6; i++) begin
      {sdIn, txdIn, lightIn} = VEC[i][4:2];
      waitCyc(4);
      check("R2/R9 led", ledOn, VEC[i][1]);
      check("R5/R9 rxd", rxdOut, VEC[i][0]);
      check("R5 oe", rxdOe, 1'b1);
    end

    // R3: emitter guard time
    doReset();
    txdIn = 1'b1;
    waitCyc(3);
    check("R2 led on", ledOn, 1'b1);
    waitCyc(LED_CYC - 10);
    check("R3 led before timeout", ledOn, 1'b1);
    waitCyc(15);
    check("R3 led after timeout", ledOn, 1'b0);
    check("R3 rxd after timeout", rxdOut, 1'b1);
    waitCyc(50);
    check("R3 led stays off", ledOn, 1'b0);

    // R4: guard restarts after TXD low
    txdIn = 1'b0;
    waitCyc(5);
    check("R2 led off", ledOn, 1'b0);
    txdIn = 1'b1;
    waitCyc(LED_CYC - 5);
    check("R4 full second pulse", ledOn, 1'b1);
    txdIn = 1'b0;
    waitCyc(5);

    // R5: short SD pulse, no shutdown
    sdIn = 1'b1;
    waitCyc(SHDN_CYC / 2);
    check("R5 oe short pulse", rxdOe, 1'b1);
    check("R5 rxd high", rxdOut, 1'b1);
    sdIn = 1'b0;
    waitCyc(5);

    // R6: qualified shutdown ignores TXD and light
    sdIn = 1'b1; txdIn = 1'b1; lightIn = 1'b1;
    waitCyc(SHDN_CYC + 10);
    check("R6 oe off", rxdOe, 1'b0);
    check("R6 led off", ledOn, 1'b0);
    // R8: exit latches bandwidth from TXD (high)
    sdIn = 1'b0;
    waitCyc(5);
    check("R8 bw after exit", bwHigh, 1'b1);
    check("R8 oe restored", rxdOe, 1'b1);
    txdIn = 1'b0; lightIn = 1'b0;
    waitCyc(5);
    check("R7 bw holds", bwHigh, 1'b1);

    // R7: short pulse with TXD low selects low bandwidth
    sdIn = 1'b1;
    waitCyc(10);
    sdIn = 1'b0;
    waitCyc(5);
    check("R7 bw low", bwHigh, 1'b0);
    // R7: short pulse with TXD high selects high bandwidth
    sdIn = 1'b1;
    waitCyc(5);
    txdIn = 1'b1;
    waitCyc(5);
    sdIn = 1'b0;
    waitCyc(5);
    check("R7 bw high", bwHigh, 1'b1);
    txdIn = 1'b0;
    waitCyc(5);
    check("R7 bw kept", bwHigh, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule